// File: doc/BRIEF.md
# I2C-to-TPM Register Address Bridge

This block sits behind an I2C target controller and turns each write packet the controller receives into an access to a TPM register port. The target controller hands over the packet's bytes one at a time and then marks the packet's end. The first byte is a compact index. A fixed table maps that index to a 16-bit TPM register address and an access kind: one byte, four bytes, or a variable-length FIFO stream.

The bridge infers the direction from the packet length. A packet that holds only the index byte is a read request. The bridge reads the mapped register one byte at a time and queues each byte for the controller's following read phase. When every byte is queued, it pulses a done strobe. A longer packet is a write. The bridge checks the write against the register size and then forwards it byte by byte, or drops it.

The bridge keeps no state from one packet to the next. The exception is a saturating count of dropped packets. The sender must not start a new packet until the previous one has been fully processed, which takes at most 64 cycles.

Top module: `i2c_tpm_bridge`

## Requirements
- R1: While reset is asserted, and after it, all strobes are low, reg_addr_o and reg_off_o are 0, and err_cnt_o is 0.
- R2: The index map is: index 0x00 → address 0x000, one byte; index 0x01 → address 0x018, four bytes; index 0x05 → address 0x024, FIFO stream; index 0x06 → address 0xF00, four bytes. Every access is issued on reg_addr_o with the mapped address.
- R3: A packet of exactly one byte is a read. Starting in the cycle after rx_end_i is sampled, the bridge asserts reg_rd_o and tx_push_o for N consecutive cycles. In each of these cycles it drives reg_off_o = k for k = 0..N−1 and forwards reg_rdata_i on tx_data_o.
- R4: Multi-byte values are little-endian. Offset 0 is the least significant byte and is the first byte sent or received after the index. Only whole-register accesses are made.
- R5: After the last byte of a read is queued, tx_done_o pulses high for exactly one cycle. For N = 0 the pulse comes in the cycle after rx_end_i.
- R6: For a FIFO read, N equals burst_cnt_i as sampled together with rx_end_i. For a burst count of 0, nothing is pushed, but the done pulse is still given.
- R7: A write to a one-byte or four-byte register is forwarded only when the packet carries exactly that many data bytes. Otherwise no reg_wr_o pulse occurs and err_cnt_o increments by one.
- R8: A FIFO write of 1 to 62 data bytes is forwarded as reg_wr_o pulses in consecutive cycles, starting the cycle after rx_end_i. Pulse k carries offset k and data byte k. A FIFO write with more than 62 data bytes is dropped and counted.
- R9: An empty packet, or a packet whose first byte is not in the map, causes no access and no transmit activity, and err_cnt_o increments by one.
- R10: err_cnt_o never decreases, and it saturates at its all-ones value.
- R11: A write packet produces no tx_push_o and no tx_done_o.
- R12: reg_rd_o and reg_wr_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received packet byte is present |
| rx_data_i | input | 8 | Received packet byte |
| rx_end_i | input | 1 | End of the received packet (a cycle with no byte) |
| burst_cnt_i | input | 6 | Current burst count from the status register |
| reg_rd_o | output | 1 | Register port read strobe |
| reg_wr_o | output | 1 | Register port write strobe |
| reg_addr_o | output | 16 | Mapped TPM register address |
| reg_off_o | output | 6 | Byte offset within the register or stream |
| reg_wdata_o | output | 8 | Write data byte |
| reg_rdata_i | input | 8 | Read data byte, valid in the same cycle as reg_rd_o |
| tx_push_o | output | 1 | Push one byte into the transmit buffer |
| tx_data_o | output | 8 | Byte pushed into the transmit buffer |
| tx_done_o | output | 1 | All read bytes are queued |
| err_cnt_o | output | 8 | Saturating count of dropped packets |

## Verification
There is one register stage between the end-of-packet strobe and the first access.

- **Reads:** byte k of a read appears on the register port and the transmit push k+1 cycles after the edge that samples rx_end_i. The done pulse follows one cycle after the last byte.
- **Writes:** a write's byte k is issued in the same cycle slot as a read's byte k.
- **Drops:** a dropped packet changes the error count at the edge that samples rx_end_i.

The bench stamps each edge with a cycle number and samples every output on the falling edge. It records the cycle stamp of each strobe and compares that stamp against the number computed from the cycle in which it raised rx_end_i. Error counts are read only after the longest possible sequence has finished.

// File: rtl/i2c_tpm_br_pkg.sv
package i2c_tpm_br_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_BYTE = 2'd1,
    K_WORD = 2'd2,
    K_FIFO = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    reg_kind_e kind;
    logic [15:0] addr;
  } map_ent_t;

  localparam logic [15:0] ADDR_ACCESS = 16'h0000;
  localparam logic [15:0] ADDR_STATUS = 16'h0018;
  localparam logic [15:0] ADDR_FIFO   = 16'h0024;
  localparam logic [15:0] ADDR_DIDVID = 16'h0F00;

  function automatic map_ent_t map_lookup(input logic [7:0] idx);
    map_ent_t e;
    e = '{hit: 1'b0, kind: K_NONE, addr: 16'h0000};
    case (idx)
      8'h00: e = '{hit: 1'b1, kind: K_BYTE, addr: ADDR_ACCESS};
      8'h01: e = '{hit: 1'b1, kind: K_WORD, addr: ADDR_STATUS};
      8'h05: e = '{hit: 1'b1, kind: K_FIFO, addr: ADDR_FIFO};
      8'h06: e = '{hit: 1'b1, kind: K_WORD, addr: ADDR_DIDVID};
      default: ;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/i2c_tpm_map.sv
module i2c_tpm_map
  import i2c_tpm_br_pkg::*;
(
  input  logic [7:0] idx_i,
  output map_ent_t   ent_o
);
  always_comb ent_o = map_lookup(idx_i);
endmodule

// File: rtl/i2c_tpm_pktbuf.sv
module i2c_tpm_pktbuf #(
  parameter  int DEPTH = 64,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [7:0]    data_i,
  input  logic          end_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [LW-1:0] len_o,
  output logic          ovf_o,
  output logic [7:0]    first_o,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem [DEPTH];
  logic       room;

  assign room = (len_o < LW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (en_i && valid_i && room) mem[len_o[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o <= '0;
      ovf_o <= 1'b0;
    end else if (en_i) begin
      if (end_i) begin
        len_o <= '0;
        ovf_o <= 1'b0;
      end else if (valid_i) begin
        if (room) len_o <= len_o + LW'(1);
        else      ovf_o <= 1'b1;
      end
    end
  end

  assign first_o   = (len_o != '0) ? mem[0] : 8'h00;
  assign rd_data_o = mem[rd_idx_i];

  a_r8_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o <= LW'(DEPTH));
endmodule

// File: rtl/i2c_tpm_seq.sv
module i2c_tpm_seq
  import i2c_tpm_br_pkg::*;
#(
  parameter  int DEPTH    = 64,
  parameter  int FIFO_MAX = 62,
  parameter  int BURST_W  = 6,
  parameter  int ERR_W    = 8,
  localparam int LW       = $clog2(DEPTH + 1),
  localparam int AW       = $clog2(DEPTH),
  localparam int NW       = (LW > BURST_W) ? LW : BURST_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               end_i,
  input  logic [LW-1:0]      len_i,
  input  logic               ovf_i,
  input  map_ent_t           ent_i,
  input  logic [BURST_W-1:0] burst_i,
  output logic               idle_o,
  output logic [AW-1:0]      cnt_o,
  output logic               reg_rd_o,
  output logic               reg_wr_o,
  output logic [15:0]        reg_addr_o,
  output logic               tx_push_o,
  output logic               tx_done_o,
  output logic [ERR_W-1:0]   err_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} st_e;
  st_e st_q;
  logic [NW-1:0] cnt_q, num_q, num_d, dlen;
  logic drop, go_rd, go_wr;

  always_comb begin
    drop  = 1'b0;
    go_rd = 1'b0;
    go_wr = 1'b0;
    num_d = '0;
    dlen  = NW'(len_i) - NW'(1);
    if (st_q == S_IDLE && end_i) begin
      if (len_i == '0 || !ent_i.hit) begin
        drop = 1'b1;
      end else if (len_i == LW'(1)) begin
        go_rd = 1'b1;
        case (ent_i.kind)
          K_BYTE:  num_d = NW'(1);
          K_WORD:  num_d = NW'(4);
          default: num_d = NW'(burst_i);
        endcase
      end else if (ent_i.kind == K_FIFO) begin
        if (ovf_i || dlen > NW'(FIFO_MAX)) drop = 1'b1;
        else begin go_wr = 1'b1; num_d = dlen; end
      end else if (dlen != ((ent_i.kind == K_BYTE) ? NW'(1) : NW'(4))) begin
        drop = 1'b1;
      end else begin
        go_wr = 1'b1;
        num_d = dlen;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      num_q      <= '0;
      reg_addr_o <= '0;
      err_o      <= '0;
    end else begin
      if (drop && err_o != '1) err_o <= err_o + ERR_W'(1);
      case (st_q)
        S_IDLE: begin
          cnt_q <= '0;
          num_q <= num_d;
          if (go_rd || go_wr) reg_addr_o <= ent_i.addr;
          if (go_wr)      st_q <= S_WR;
          else if (go_rd) st_q <= (num_d == '0) ? S_DONE : S_RD;
        end
        S_RD: begin
          cnt_q <= cnt_q + NW'(1);
          if (cnt_q == num_q - NW'(1)) st_q <= S_DONE;
        end
        S_WR: begin
          cnt_q <= cnt_q + NW'(1);
          if (cnt_q == num_q - NW'(1)) begin
            st_q       <= S_IDLE;
            reg_addr_o <= '0;
          end
        end
        default: begin
          st_q       <= S_IDLE;
          reg_addr_o <= '0;
        end
      endcase
    end
  end

  assign idle_o    = (st_q == S_IDLE);
  assign cnt_o     = cnt_q[AW-1:0];
  assign reg_rd_o  = (st_q == S_RD);
  assign reg_wr_o  = (st_q == S_WR);
  assign tx_push_o = (st_q == S_RD);
  assign tx_done_o = (st_q == S_DONE);

  a_r12_rd_wr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);
  a_r10_err_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> err_o >= $past(err_o));
  a_r2_addr_mapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o || reg_wr_o) |-> (reg_addr_o == ADDR_ACCESS || reg_addr_o == ADDR_STATUS ||
                                reg_addr_o == ADDR_FIFO || reg_addr_o == ADDR_DIDVID));
  a_r8_fifo_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_addr_o == ADDR_FIFO) |-> (NW'(cnt_o) < NW'(FIFO_MAX)));
  a_r11_wr_no_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !tx_done_o);
endmodule

// File: rtl/i2c_tpm_bridge.sv
module i2c_tpm_bridge
  import i2c_tpm_br_pkg::*;
#(
  parameter  int DEPTH    = 64,
  parameter  int FIFO_MAX = 62,
  parameter  int BURST_W  = 6,
  parameter  int ERR_W    = 8,
  localparam int LW       = $clog2(DEPTH + 1),
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_end_i,
  input  logic [BURST_W-1:0] burst_cnt_i,
  output logic               reg_rd_o,
  output logic               reg_wr_o,
  output logic [15:0]        reg_addr_o,
  output logic [AW-1:0]      reg_off_o,
  output logic [7:0]         reg_wdata_o,
  input  logic [7:0]         reg_rdata_i,
  output logic               tx_push_o,
  output logic [7:0]         tx_data_o,
  output logic               tx_done_o,
  output logic [ERR_W-1:0]   err_cnt_o
);
  logic [LW-1:0] len;
  logic          ovf, idle;
  logic [7:0]    first_b, rd_b;
  logic [AW-1:0] cnt;
  map_ent_t      ent;

  i2c_tpm_pktbuf #(.DEPTH(DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .en_i      (idle),
    .valid_i   (rx_valid_i),
    .data_i    (rx_data_i),
    .end_i     (rx_end_i),
    .rd_idx_i  (cnt + AW'(1)),
    .len_o     (len),
    .ovf_o     (ovf),
    .first_o   (first_b),
    .rd_data_o (rd_b)
  );

  i2c_tpm_map u_map (.idx_i(first_b), .ent_o(ent));

  i2c_tpm_seq #(
    .DEPTH(DEPTH), .FIFO_MAX(FIFO_MAX), .BURST_W(BURST_W), .ERR_W(ERR_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .end_i      (rx_end_i),
    .len_i      (len),
    .ovf_i      (ovf),
    .ent_i      (ent),
    .burst_i    (burst_cnt_i),
    .idle_o     (idle),
    .cnt_o      (cnt),
    .reg_rd_o   (reg_rd_o),
    .reg_wr_o   (reg_wr_o),
    .reg_addr_o (reg_addr_o),
    .tx_push_o  (tx_push_o),
    .tx_done_o  (tx_done_o),
    .err_o      (err_cnt_o)
  );

  assign reg_off_o   = (reg_rd_o || reg_wr_o) ? cnt : '0;
  assign reg_wdata_o = reg_wr_o ? rd_b : 8'h00;
  assign tx_data_o   = tx_push_o ? reg_rdata_i : 8'h00;
endmodule

// File: tb/tb_i2c_tpm_bridge.sv
`timescale 1ns/1ps
module tb_i2c_tpm_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_end = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [5:0] burst = 6'd0;
  logic reg_rd, reg_wr, tx_push, tx_done;
  logic [15:0] reg_addr;
  logic [5:0] reg_off;
  logic [7:0] reg_wdata, reg_rdata, tx_data, err_cnt;

  always #10 clk = ~clk;

  function automatic logic [7:0] model(input logic [15:0] a, input logic [5:0] o);
    logic [7:0] r;
    r = (a[7:0] ^ a[15:8]) + (8'(o) * 8'd17) + 8'h3C;
    return r;
  endfunction
  assign reg_rdata = model(reg_addr, reg_off);

  i2c_tpm_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_end_i(rx_end), .burst_cnt_i(burst), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
    .reg_addr_o(reg_addr), .reg_off_o(reg_off), .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata), .tx_push_o(tx_push), .tx_data_o(tx_data),
    .tx_done_o(tx_done), .err_cnt_o(err_cnt)
  );

  int cyc = 0, nchk = 0, nerr = 0, e_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event logs, sampled on the falling edge
  int np = 0, nw = 0, nd = 0, done_c = 0, both = 0;
  logic [7:0] p_d [128]; int p_c [128]; logic [15:0] p_a [128]; logic [5:0] p_o [128];
  logic [7:0] w_d [128]; int w_c [128]; logic [15:0] w_a [128]; logic [5:0] w_o [128];
  logic [7:0] pkt [64];

  always @(negedge clk) if (rst_n) begin
    if (reg_rd && reg_wr) both++;
    if (tx_push && np < 128) begin
      p_d[np] = tx_data; p_c[np] = cyc; p_a[np] = reg_addr; p_o[np] = reg_off; np++;
    end
    if (reg_wr && nw < 128) begin
      w_d[nw] = reg_wdata; w_c[nw] = cyc; w_a[nw] = reg_addr; w_o[nw] = reg_off; nw++;
    end
    if (tx_done) begin nd++; done_c = cyc; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int n, input int settle);
    np = 0; nw = 0; nd = 0; both = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = pkt[i];
    end
    @(negedge clk); rx_valid = 1'b0; rx_end = 1'b1; e_cyc = cyc + 1;
    @(negedge clk); rx_end = 1'b0;
    repeat (settle) @(negedge clk);
  endtask

  task automatic t_read(input string req, input logic [7:0] idx, input logic [15:0] a, input int n, input logic [5:0] b);
    int e0;
    e0 = err_cnt;
    burst = b; pkt[0] = idx;
    send(1, 70);
    chk(np == n, req, "push count", np, n);
    for (int k = 0; k < n && k < np; k++) begin
      chk(p_d[k] == model(a, 6'(k)), "R4", "read byte order", p_d[k], model(a, 6'(k)));
      chk(p_a[k] == a && p_o[k] == 6'(k), "R2", "read address/offset", {p_a[k], 2'b00, p_o[k]}, {a, 2'b00, 6'(k)});
      chk(p_c[k] == e_cyc + k, "R3", "push cycle", p_c[k] - e_cyc, k);
    end
    chk(nd == 1 && done_c == e_cyc + n, "R5", "done pulse", (nd << 16) | (done_c - e_cyc), (1 << 16) | n);
    chk(nw == 0 && err_cnt == 8'(e0), "R3", "no write/no error", (nw << 8) | err_cnt, e0);
  endtask

  task automatic t_write(input string req, input logic [7:0] idx, input logic [15:0] a, input int n);
    int e0;
    e0 = err_cnt;
    pkt[0] = idx;
    for (int k = 0; k < n; k++) pkt[k+1] = 8'(k * 7 + 3);
    send(n + 1, 70);
    chk(nw == n, req, "write count", nw, n);
    for (int k = 0; k < n && k < nw; k++) begin
      chk(w_d[k] == 8'(k * 7 + 3) && w_o[k] == 6'(k), "R4", "write byte/offset", {w_d[k], 2'b00, w_o[k]}, {8'(k * 7 + 3), 2'b00, 6'(k)});
      chk(w_a[k] == a && w_c[k] == e_cyc + k, req, "write addr/cycle", w_c[k] - e_cyc, k);
    end
    chk(np == 0 && nd == 0, "R11", "no tx on write", (np << 8) | nd, 0);
    chk(err_cnt == 8'(e0) && both == 0, "R12", "no error, no overlap", err_cnt, e0);
  endtask

  task automatic t_drop(input string req, input string what, input int len);
    int e0;
    e0 = err_cnt;
    send(len, 70);
    chk(nw == 0 && np == 0 && nd == 0, req, what, (nw << 16) | (np << 8) | nd, 0);
    chk(err_cnt == 8'(e0 + 1), req, "error increment", err_cnt, e0 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({reg_rd, reg_wr, tx_push, tx_done} == 4'b0 && reg_addr == 16'h0 && reg_off == 6'h0 && err_cnt == 8'h0,
        "R1", "outputs in reset", {reg_rd, reg_wr, tx_push, tx_done, err_cnt}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({reg_rd, reg_wr, tx_push, tx_done} == 4'b0 && err_cnt == 8'h0, "R1", "outputs after reset",
        {reg_rd, reg_wr, tx_push, tx_done, err_cnt}, 0);

    t_read("R2", 8'h00, 16'h0000, 1, 6'd9);
    t_read("R2", 8'h01, 16'h0018, 4, 6'd9);
    t_read("R2", 8'h06, 16'h0F00, 4, 6'd9);
    t_read("R6", 8'h05, 16'h0024, 5, 6'd5);
    t_read("R6", 8'h05, 16'h0024, 0, 6'd0);
    t_read("R6", 8'h05, 16'h0024, 63, 6'd63);

    t_write("R7", 8'h01, 16'h0018, 4);
    t_write("R7", 8'h00, 16'h0000, 1);
    t_write("R7", 8'h06, 16'h0F00, 4);
    t_write("R8", 8'h05, 16'h0024, 1);
    t_write("R8", 8'h05, 16'h0024, 62);

    pkt[0] = 8'h01; for (int k = 1; k < 64; k++) pkt[k] = 8'(k);
    t_drop("R7", "short status write", 4);
    pkt[0] = 8'h00;
    t_drop("R7", "long access write", 3);
    pkt[0] = 8'h06;
    t_drop("R7", "long id write", 6);
    pkt[0] = 8'h05;
    t_drop("R8", "63-byte fifo write", 64);
    t_drop("R9", "empty packet", 0);
    pkt[0] = 8'h02;
    t_drop("R9", "unknown index read", 1);
    pkt[0] = 8'h07;
    t_drop("R9", "unknown index write", 5);

    // R10 saturation
    for (int i = 0; i < 260; i++) send(0, 1);
    chk(err_cnt == 8'hFF, "R10", "saturated count", err_cnt, 8'hFF);
    send(0, 2);
    chk(err_cnt == 8'hFF, "R10", "stays saturated", err_cnt, 8'hFF);
    t_read("R3", 8'h01, 16'h0018, 4, 6'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule